// File: doc/BRIEF.md
# Dual-Format Serial Audio Transmitter

This block is the master of a three-wire serial audio link. From a faster system clock it makes a bit clock and a channel-select clock, and it drives one data line. Stereo 24-bit PCM samples come in as a left/right pair through a valid/ready handshake. Each frame has 64 bit clocks, split into a 32-bit left slot and then a 32-bit right slot. Each sample is sent most-significant bit first, and the rest of the slot is padded with zeros.

A single format input picks one of two framings. With the input at 0 the framing is I2S: the channel clock is low for left, and the MSB comes one bit clock after the channel clock toggles. With the input at 1 the framing is left-justified: the channel clock is high for left, and the MSB comes on the same edge as the toggle. The format input and the divider setting are read only when a new frame starts. The incoming pair waits in a pending register and moves to the active register at the frame start. If no pair is pending at that point, the previous pair is sent again and a sticky underrun flag is raised.

The framing controller has three states. `ST_WAIT` is the state after reset, before any bit is sent. `ST_LEFT` covers the left slot and `ST_RIGHT` covers the right slot. It has three transitions. WAIT goes to LEFT on the first falling edge of the bit clock, and that edge is the first frame start. LEFT goes to RIGHT on the falling edge after slot bit 31. RIGHT goes to LEFT on the falling edge after slot bit 31, and that edge is a frame start.

Top module: `pcm_serial_tx`

## Requirements
- R1: While `rst_n` is low, `bclk`, `lrclk`, `sdata`, `smp_ready` and `underrun` are all 0.
- R2: One `bclk` period is 2·H system clocks with equal high and low phases. H is the value of `half_div` captured before the first frame and again at each frame start. It stays fixed for the whole frame.
- R3: A frame is 64 bit clocks: 32 for the left slot, then 32 for the right slot. The first frame after reset begins with the left slot.
- R4: `sdata` and `lrclk` change only on the system-clock edge where `bclk` goes from 1 to 0.
- R5: With `fmt_sel` = 1 (left-justified), `lrclk` is 1 during the left slot and 0 during the right slot. The sample MSB is in slot bit 0.
- R6: With `fmt_sel` = 0 (I2S), `lrclk` is 0 during the left slot and 1 during the right slot. Slot bit 0 is 0 and the sample MSB is in slot bit 1.
- R7: The 24 sample bits go out MSB first in consecutive slot bits. Every other slot bit is 0.
- R8: A pair is accepted on a clock where `smp_valid` and `smp_ready` are both 1. `smp_ready` is 0 on the next clock and stays 0 until the pair moves to the active register at a frame start.
- R9: `fmt_sel` is sampled only at a frame start. A change in the middle of a frame does not affect that frame.
- R10: If no pair is pending at a frame start, the previous pair is sent again and `underrun` goes to 1. It stays 1 until reset.
- R11: A `half_div` of 0 is treated as 1, so the bit clock runs at half the system clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 1 | Framing select: 0 = I2S, 1 = left-justified |
| half_div | input | HP_W | System clocks per half bit-clock period (0 is read as 1) |
| smp_valid | input | 1 | A sample pair is offered |
| smp_ready | output | 1 | The pending register is free |
| smp_left | input | SMP_W | Left-channel sample |
| smp_right | input | SMP_W | Right-channel sample |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Channel-select clock |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | Sticky flag: a frame started with no new pair |

## Verification
`bclk`, `sdata` and `lrclk` all come from registers that update on the same system edge. A bit driven at a falling edge is therefore stable by the next `bclk` rise, H system clocks later. The bench watches the outputs on the falling system-clock edge and records each data bit at the first such sample that shows `bclk` high. Each frame is compared only after its 64th rise, against the format, divider and sample pair that were loaded before that frame's first falling edge. `smp_ready` is checked on the first system clock after the handshake. `underrun` is checked just before the frame start with no pending pair and again after it.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } tx_state_e;

    localparam logic FMT_I2S = 1'b0;
    localparam logic FMT_LJ  = 1'b1;

endpackage

// File: rtl/ptx_clkgen.sv
module ptx_clkgen #(
    parameter int HP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [HP_W-1:0] half_in,
    input  logic            wait_i,
    input  logic            frame_end_i,
    output logic            bclk_o,
    output logic            fall_evt_o
);
    logic [HP_W-1:0] cnt_q;
    logic [HP_W-1:0] half_q;
    logic [HP_W-1:0] half_san;
    logic [HP_W-1:0] half_eff;
    logic            bclk_q;
    logic            term;

    always_comb begin
        half_san   = (half_in == '0) ? HP_W'(1) : half_in;
        half_eff   = wait_i ? half_san : half_q;
        term       = (cnt_q >= half_eff - 1'b1);
        fall_evt_o = term && bclk_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            half_q <= HP_W'(1);
            bclk_q <= 1'b0;
        end else begin
            if (wait_i || (fall_evt_o && frame_end_i))
                half_q <= half_san;
            if (term) begin
                cnt_q  <= '0;
                bclk_q <= ~bclk_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign bclk_o = bclk_q;

    // R11
    hp_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_q != '0);

endmodule

// File: rtl/ptx_sbuf.sv
module ptx_sbuf #(
    parameter int SMP_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [SMP_W-1:0] left_i,
    input  logic [SMP_W-1:0] right_i,
    input  logic             take_i,
    output logic             ready_o,
    output logic [SMP_W-1:0] sel_l_o,
    output logic [SMP_W-1:0] sel_r_o,
    output logic             underrun_o
);
    logic [SMP_W-1:0] pend_l_q, pend_r_q, act_l_q, act_r_q;
    logic             pend_full_q, pend_nxt, ready_q, unr_q, acc;

    always_comb begin
        acc      = valid_i && ready_q;
        pend_nxt = acc ? 1'b1 : (take_i ? 1'b0 : pend_full_q);
        sel_l_o  = (take_i && pend_full_q) ? pend_l_q : act_l_q;
        sel_r_o  = (take_i && pend_full_q) ? pend_r_q : act_r_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_l_q    <= '0;
            pend_r_q    <= '0;
            act_l_q     <= '0;
            act_r_q     <= '0;
            pend_full_q <= 1'b0;
            ready_q     <= 1'b0;
            unr_q       <= 1'b0;
        end else begin
            pend_full_q <= pend_nxt;
            ready_q     <= !pend_nxt;
            if (acc) begin
                pend_l_q <= left_i;
                pend_r_q <= right_i;
            end
            if (take_i && pend_full_q) begin
                act_l_q <= pend_l_q;
                act_r_q <= pend_r_q;
            end
            if (take_i && !pend_full_q)
                unr_q <= 1'b1;
        end
    end

    assign ready_o    = ready_q;
    assign underrun_o = unr_q;

    // R10
    unr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unr_q |=> unr_q);

    // R8
    take_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && pend_full_q) |=> ready_q);

endmodule

// File: rtl/ptx_framer.sv
module ptx_framer
    import ptx_pkg::*;
#(
    parameter int SMP_W  = 24,
    parameter int SLOT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_evt_i,
    input  logic             bclk_i,
    input  logic             fmt_sel_i,
    input  logic [SMP_W-1:0] sel_l_i,
    input  logic [SMP_W-1:0] sel_r_i,
    output logic             take_o,
    output logic             wait_o,
    output logic             frame_end_o,
    output logic             sdata_o,
    output logic             lrclk_o
);
    localparam int BIT_W = $clog2(SLOT_W);

    tx_state_e        state_q, state_nxt;
    logic [BIT_W-1:0] bit_q, bit_nxt;
    logic             fmt_q, fmt_nxt;
    logic             last;
    logic             sdata_q, lrclk_q;
    logic             data_nxt, lr_nxt;
    logic [BIT_W:0]   dpos, off;
    logic [SMP_W-1:0] word, shf;

    always_comb begin
        last        = (bit_q == BIT_W'(SLOT_W - 1));
        take_o      = fall_evt_i && last && (state_q != ST_LEFT);
        wait_o      = (state_q == ST_WAIT);
        frame_end_o = (state_q == ST_RIGHT) && last;
        state_nxt   = state_q;
        unique case (state_q)
            ST_WAIT:  if (fall_evt_i)         state_nxt = ST_LEFT;
            ST_LEFT:  if (fall_evt_i && last) state_nxt = ST_RIGHT;
            ST_RIGHT: if (fall_evt_i && last) state_nxt = ST_LEFT;
            default:                          state_nxt = ST_WAIT;
        endcase
        bit_nxt  = fall_evt_i ? (last ? '0 : bit_q + 1'b1) : bit_q;
        fmt_nxt  = take_o ? fmt_sel_i : fmt_q;
        word     = (state_nxt == ST_RIGHT) ? sel_r_i : sel_l_i;
        off      = (fmt_nxt == FMT_LJ) ? '0 : (BIT_W+1)'(1);
        dpos     = {1'b0, bit_nxt} - off;
        shf      = word << dpos;
        data_nxt = ({1'b0, bit_nxt} >= off) && (int'(dpos) < SMP_W) && shf[SMP_W-1];
        lr_nxt   = (state_nxt == ST_RIGHT) ^ fmt_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            bit_q   <= BIT_W'(SLOT_W - 1);
            fmt_q   <= 1'b0;
        end else begin
            state_q <= state_nxt;
            bit_q   <= bit_nxt;
            fmt_q   <= fmt_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdata_q <= 1'b0;
            lrclk_q <= 1'b0;
        end else if (fall_evt_i) begin
            sdata_q <= data_nxt;
            lrclk_q <= lr_nxt;
        end
    end

    assign sdata_o = sdata_q;
    assign lrclk_o = lrclk_q;

    // R4
    sdat_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata_q) |-> $fell(bclk_i));

    // R4
    lrck_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrclk_q) |-> $fell(bclk_i));

    // R9
    fmt_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fmt_q) |-> (state_q == ST_LEFT && bit_q == '0));

endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx #(
    parameter int SMP_W  = 24,
    parameter int SLOT_W = 32,
    parameter int HP_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fmt_sel,
    input  logic [HP_W-1:0]  half_div,
    input  logic             smp_valid,
    output logic             smp_ready,
    input  logic [SMP_W-1:0] smp_left,
    input  logic [SMP_W-1:0] smp_right,
    output logic             bclk,
    output logic             lrclk,
    output logic             sdata,
    output logic             underrun
);
    logic             fall_evt, take, in_wait, frame_end;
    logic [SMP_W-1:0] sel_l, sel_r;

    ptx_clkgen #(.HP_W(HP_W)) u_clkgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .half_in     (half_div),
        .wait_i      (in_wait),
        .frame_end_i (frame_end),
        .bclk_o      (bclk),
        .fall_evt_o  (fall_evt)
    );

    ptx_sbuf #(.SMP_W(SMP_W)) u_sbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (smp_valid),
        .left_i     (smp_left),
        .right_i    (smp_right),
        .take_i     (take),
        .ready_o    (smp_ready),
        .sel_l_o    (sel_l),
        .sel_r_o    (sel_r),
        .underrun_o (underrun)
    );

    ptx_framer #(.SMP_W(SMP_W), .SLOT_W(SLOT_W)) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall_evt_i  (fall_evt),
        .bclk_i      (bclk),
        .fmt_sel_i   (fmt_sel),
        .sel_l_i     (sel_l),
        .sel_r_i     (sel_r),
        .take_o      (take),
        .wait_o      (in_wait),
        .frame_end_o (frame_end),
        .sdata_o     (sdata),
        .lrclk_o     (lrclk)
    );

endmodule

// File: tb/test_pcm_serial_tx.sv
`timescale 1ns/1ps
module test_pcm_serial_tx;
    localparam int SW = 24;
    localparam int HW = 8;
    localparam int NV = 6;
    localparam int NF = 8;

    typedef struct packed {
        logic          fmt;
        logic [HW-1:0] half;
        logic [SW-1:0] l;
        logic [SW-1:0] r;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        {1'b0, 8'd2, 24'hA5F00F, 24'h5A0FF0},
        {1'b1, 8'd2, 24'h800001, 24'h7FFFFE},
        {1'b1, 8'd3, 24'hFFFFFF, 24'h000000},
        {1'b0, 8'd1, 24'h123456, 24'hABCDEF},
        {1'b0, 8'd0, 24'hC0FFEE, 24'h0DBEEF},
        {1'b1, 8'd4, 24'h800000, 24'h000001}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fmt_sel = 1'b0;
    logic [HW-1:0] half_div = '0;
    logic          smp_valid = 1'b0;
    logic          smp_ready;
    logic [SW-1:0] smp_left = '0;
    logic [SW-1:0] smp_right = '0;
    logic          bclk, lrclk, sdata, underrun;

    pcm_serial_tx i_pcm_serial_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt_sel   (fmt_sel),
        .half_div  (half_div),
        .smp_valid (smp_valid),
        .smp_ready (smp_ready),
        .smp_left  (smp_left),
        .smp_right (smp_right),
        .bclk      (bclk),
        .lrclk     (lrclk),
        .sdata     (sdata),
        .underrun  (underrun)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    // bus monitor, sampled on the falling system edge
    logic        p_bclk = 1'b0, p_sd = 1'b0, p_lr = 1'b0;
    int          rise_n = 0;
    int          t0 = 0;
    int          edge_bad = 0;
    int          frames_done = 0;
    logic [63:0] cur_sd = '0, cur_lr = '0;
    logic [63:0] fr_sd [NF];
    logic [63:0] fr_lr [NF];
    int          fr_per [NF];

    always @(negedge clk) begin
        int g, f, p;
        cyc++;
        if (rst_n) begin
            if ((sdata !== p_sd || lrclk !== p_lr) && !(p_bclk && !bclk))
                edge_bad++;
            if (!p_bclk && bclk) begin
                if (rise_n > 0) begin
                    g = rise_n - 1;
                    f = g / 64;
                    p = g % 64;
                    cur_sd[p] = sdata;
                    cur_lr[p] = lrclk;
                    if (p == 0) t0 = cyc;
                    if (p == 63 && f < NF) begin
                        fr_sd[f]    = cur_sd;
                        fr_lr[f]    = cur_lr;
                        fr_per[f]   = cyc - t0;
                        frames_done = f + 1;
                    end
                end
                rise_n++;
            end
        end
        p_bclk = bclk;
        p_sd   = sdata;
        p_lr   = lrclk;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_sd(input logic fm, input logic [SW-1:0] l, input logic [SW-1:0] r);
        logic [63:0] v;
        v = '0;
        for (int p = 0; p < 64; p++) begin
            int d;
            d = (p % 32) - (fm ? 0 : 1);
            if (d >= 0 && d < SW)
                v[p] = (p >= 32) ? r[SW-1-d] : l[SW-1-d];
        end
        return v;
    endfunction

    function automatic logic [63:0] exp_lr(input logic fm);
        logic [63:0] v;
        for (int p = 0; p < 64; p++)
            v[p] = (p >= 32) ^ fm;
        return v;
    endfunction

    task automatic push(input logic [SW-1:0] l, input logic [SW-1:0] r);
        do @(negedge clk); while (smp_ready !== 1'b1);
        smp_left  = l;
        smp_right = r;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R8 ready after accept", {63'd0, smp_ready}, 64'd0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        logic          fm;
        logic [HW-1:0] hv;
        logic [SW-1:0] lv, rv;
        int            he;
        fmt_sel  = VECS[0].fmt;
        half_div = VECS[0].half;
        repeat (4) @(negedge clk);
        chk("R1 reset outputs", {59'd0, bclk, lrclk, sdata, smp_ready, underrun}, 64'd0);
        rst_n = 1'b1;

        // table walk: pair i is pushed during frame i-1, settings follow it
        push(VECS[0].l, VECS[0].r);
        for (int i = 1; i < NV; i++) begin
            push(VECS[i].l, VECS[i].r);
            fmt_sel  = VECS[i].fmt;
            half_div = VECS[i].half;
        end

        // directed: starve the buffer, change format mid-frame
        do @(negedge clk); while (smp_ready !== 1'b1);
        fmt_sel  = 1'b0;
        half_div = 8'd2;
        while (frames_done < 6) @(negedge clk);
        chk("R10 no underrun while fed", {63'd0, underrun}, 64'd0);
        while (underrun !== 1'b1) @(negedge clk);
        repeat (10) @(negedge clk);
        fmt_sel = 1'b1;   // R9: must not affect frame 6
        while (frames_done < NF) @(negedge clk);

        for (int f = 0; f < NF; f++) begin
            if (f < NV) begin
                fm = VECS[f].fmt; hv = VECS[f].half; lv = VECS[f].l; rv = VECS[f].r;
            end else begin
                fm = (f == 7); hv = 8'd2; lv = VECS[NV-1].l; rv = VECS[NV-1].r;
            end
            he = (hv == 0) ? 1 : int'(hv);
            if (f >= NV)
                chk(fm ? "R10 R9 repeated data" : "R10 repeated data", fr_sd[f], exp_sd(fm, lv, rv));
            else
                chk(fm ? "R5 R7 data" : "R6 R7 data", fr_sd[f], exp_sd(fm, lv, rv));
            chk(fm ? "R3 R5 R9 lrclk" : "R3 R6 R9 lrclk", fr_lr[f], exp_lr(fm));
            chk((hv == 0) ? "R11 period" : "R2 period", 64'(fr_per[f]), 64'(63 * 2 * he));
        end
        chk("R10 underrun sticky", {63'd0, underrun}, 64'd1);
        chk("R4 edge alignment violations", 64'(edge_bad), 64'd0);
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (60000) @(negedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R3 watchdog: actual %0d frames expected %0d", frames_done, NF);
            summary();
        end
    end

endmodule